// File: doc/BRIEF.md
# Sleep-Aware Watchdog Timer

This block is a watchdog counter that runs on a dedicated watchdog clock, separate from the processor's system clock. A system clock that has been stopped by a sleep instruction does not halt it. Software must restart the count with a kick before the count runs out. When the count runs out, the block checks the core's power state. In run mode it raises a one-cycle reset request for the external reset generator. In sleep mode it raises a wake-up request for the power controller, and that request stays high until it is acknowledged. No reset occurs in that case, so execution continues where it stopped.

The kick is a single-cycle pulse in the system domain. It crosses into the watchdog domain as a toggle. The sleep-status level and the wake acknowledge each cross through a two-flop synchroniser. The enable and the prescaler select belong to the watchdog domain. A prescaler divides the watchdog clock by 2^n, with n set by a 3-bit select, and that divided clock advances an 8-bit counter. The counter therefore runs out every 256·2^n watchdog cycles. After each time-out the counter wraps back to zero and carries on counting.

Top module: `sleep_wdog`

## Requirements
- R1: After reset, both `wd_reset_o` and `wake_o` are low.
- R2: Enabling the block with select n (n=0 and n=2 checked) with `sleep_i` low and no kick makes `wd_reset_o` go high right after the 256·2^n-th rising edge of `wd_clk` counted from the enabling edge.
- R3: `wd_reset_o` is high for exactly one `wd_clk` cycle. The counter then restarts from zero without being told to, so the next pulse follows 256·2^n cycles after the previous one.
- R4: A one-cycle `kick_i` pulse in the system domain restarts the count. The next time-out comes between 256·2^n+1 and 256·2^n+5 `wd_clk` cycles after the kick, and none comes before that.
- R5: A time-out while the synchronised `sleep_i` is high raises `wake_o` and does not pulse `wd_reset_o`.
- R6: `wake_o` stays high for as long as `wake_ack_i` is low. It falls within 4 `wd_clk` cycles after `wake_ack_i` rises, and it stays low after the acknowledge is released.
- R7: The count advances and times out on schedule (256·2^n cycles) while `sys_clk` is stopped.
- R8: While `en_i` is low, neither output is asserted, however long the block waits. Setting `en_i` high again starts the count from zero, so the first time-out lands 256·2^n cycles later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; may be stopped during sleep |
| sys_rst_n | input | 1 | Active-low reset, system domain |
| kick_i | input | 1 | One-cycle restart command (system domain) |
| sleep_i | input | 1 | Core is in sleep mode (level) |
| wake_ack_i | input | 1 | Acknowledge of the wake request (level) |
| wd_clk | input | 1 | Dedicated watchdog clock |
| wd_rst_n | input | 1 | Active-low reset, watchdog domain |
| en_i | input | 1 | Watchdog enable (watchdog domain) |
| psel_i | input | 3 | Prescaler select n, divide by 2^n |
| wd_reset_o | output | 1 | One-cycle reset request on a run-mode time-out |
| wake_o | output | 1 | Wake request on a sleep-mode time-out, held until acknowledged |

## Verification
The bench measures the time-out period to the exact cycle at two prescaler settings. A prescaler that ticked one cycle early, or a counter that wrapped at 255 instead of 256, would therefore show as an off-by-one or off-by-2^n count. The bench also checks the gap between two consecutive pulses. A design that held the counter after a time-out, or that stretched the reset pulse, would fail that check.

In the sleep scenario the system clock is stopped before the count begins. A design that clocked the counter from the system domain, or that chose its action from the unsynchronised power state, would either never time out or would pulse reset. The bench then holds off the acknowledge for twenty cycles, which catches a wake output that drops on its own. It also checks that a kick restarts the count, which catches a kick lost in the clock crossing.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // Response chosen when the count runs out.
    typedef enum logic [1:0] {
        WD_ACT_NONE  = 2'd0,
        WD_ACT_RESET = 2'd1,
        WD_ACT_WAKE  = 2'd2
    } wd_act_e;

endpackage

// File: rtl/wdog_sync.sv
// Multi-stage level synchroniser into the destination clock domain.
module wdog_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d = {stg_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/wdog_toggle_xfer.sv
// Carries single-cycle pulses across clock domains as toggles of a level.
module wdog_toggle_xfer #(
    parameter int SYNC_STAGES = 2
) (
    input  logic src_clk,
    input  logic src_rst_n,
    input  logic pulse_i,
    input  logic dst_clk,
    input  logic dst_rst_n,
    output logic pulse_o
);

    logic tgl_d, tgl_q;
    logic tgl_s;
    logic seen_d, seen_q;

    always_comb begin
        tgl_d = tgl_q ^ pulse_i;
    end

    always_ff @(posedge src_clk or negedge src_rst_n) begin
        if (!src_rst_n) tgl_q <= 1'b0;
        else            tgl_q <= tgl_d;
    end

    wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_tgl_sync (
        .clk   (dst_clk),
        .rst_n (dst_rst_n),
        .d_i   (tgl_q),
        .q_o   (tgl_s)
    );

    always_comb begin
        seen_d = tgl_s;
    end

    always_ff @(posedge dst_clk or negedge dst_rst_n) begin
        if (!dst_rst_n) seen_q <= 1'b0;
        else            seen_q <= seen_d;
    end

    assign pulse_o = tgl_s ^ seen_q;

endmodule

// File: rtl/wdog_core.sv
// Prescaler, time-out counter and power-state dependent response.
module wdog_core
    import wdog_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [PSEL_W-1:0] psel_i,
    input  logic              clr_i,
    input  logic              sleep_i,
    input  logic              ack_i,
    output logic              rst_o,
    output logic              wake_o
);

    localparam int PSC_W = (1 << PSEL_W) - 1;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic [CNT_W-1:0] cnt;
        logic             rst;
        logic             wake;
    } core_st_t;

    core_st_t         st_d, st_q;
    logic [PSC_W-1:0] mask;
    logic             tick;
    logic             fire;
    wd_act_e          act;

    always_comb begin
        mask = (PSC_W'(1) << psel_i) - PSC_W'(1);
        tick = ((st_q.psc & mask) == mask);
        fire = en_i && !clr_i && tick && (st_q.cnt == '1);

        act = WD_ACT_NONE;
        if (fire) act = sleep_i ? WD_ACT_WAKE : WD_ACT_RESET;

        st_d     = st_q;
        st_d.rst = 1'b0;

        if (!en_i || clr_i) begin
            st_d.psc = '0;
            st_d.cnt = '0;
        end else begin
            st_d.psc = st_q.psc + PSC_W'(1);
            if (tick) st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        if (st_q.wake && ack_i) st_d.wake = 1'b0;

        unique case (act)
            WD_ACT_RESET: st_d.rst  = 1'b1;
            WD_ACT_WAKE:  st_d.wake = 1'b1;
            default:      ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rst_o  = st_q.rst;
    assign wake_o = st_q.wake;

    // R3: reset request never lasts longer than one cycle
    p_rst_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rst_o |=> !rst_o);

    // R5: a sleeping time-out wakes and never resets
    p_sleep_no_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && sleep_i) |=> (wake_o && !rst_o));

    // R6: wake request held until acknowledged
    p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_o && !ack_i) |=> wake_o);

    // R8: disabled watchdog raises no reset
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !rst_o);

    // R4: a restart cannot be followed at once by a time-out
    p_clear_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> !rst_o);

endmodule

// File: rtl/sleep_wdog.sv
module sleep_wdog #(
    parameter int CNT_W       = 8,
    parameter int PSEL_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              sys_clk,
    input  logic              sys_rst_n,
    input  logic              kick_i,
    input  logic              sleep_i,
    input  logic              wake_ack_i,
    input  logic              wd_clk,
    input  logic              wd_rst_n,
    input  logic              en_i,
    input  logic [PSEL_W-1:0] psel_i,
    output logic              wd_reset_o,
    output logic              wake_o
);

    logic clr_w;
    logic sleep_w;
    logic ack_w;

    wdog_toggle_xfer #(.SYNC_STAGES(SYNC_STAGES)) u_kick_xfer (
        .src_clk   (sys_clk),
        .src_rst_n (sys_rst_n),
        .pulse_i   (kick_i),
        .dst_clk   (wd_clk),
        .dst_rst_n (wd_rst_n),
        .pulse_o   (clr_w)
    );

    wdog_sync #(.W(2), .STAGES(SYNC_STAGES)) u_lvl_sync (
        .clk   (wd_clk),
        .rst_n (wd_rst_n),
        .d_i   ({sleep_i, wake_ack_i}),
        .q_o   ({sleep_w, ack_w})
    );

    wdog_core #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_core (
        .clk     (wd_clk),
        .rst_n   (wd_rst_n),
        .en_i    (en_i),
        .psel_i  (psel_i),
        .clr_i   (clr_w),
        .sleep_i (sleep_w),
        .ack_i   (ack_w),
        .rst_o   (wd_reset_o),
        .wake_o  (wake_o)
    );

endmodule

// File: tb/sleep_wdog_test.sv
module sleep_wdog_test;

    logic       sys_clk = 1'b0;
    logic       wd_clk  = 1'b0;
    logic       sys_rst_n = 1'b0;
    logic       wd_rst_n  = 1'b0;
    logic       kick = 1'b0;
    logic       sleep = 1'b0;
    logic       ack = 1'b0;
    logic       en = 1'b0;
    logic [2:0] psel = 3'd0;
    logic       wd_reset;
    logic       wake;
    bit         sclk_run = 1'b1;
    bit         finished = 1'b0;
    int         checks = 0;
    int         errors = 0;

    sleep_wdog uut (
        .sys_clk    (sys_clk),
        .sys_rst_n  (sys_rst_n),
        .kick_i     (kick),
        .sleep_i    (sleep),
        .wake_ack_i (ack),
        .wd_clk     (wd_clk),
        .wd_rst_n   (wd_rst_n),
        .en_i       (en),
        .psel_i     (psel),
        .wd_reset_o (wd_reset),
        .wake_o     (wake)
    );

    always #4 wd_clk = ~wd_clk;   // 125 MHz watchdog clock

    always begin
        #5;
        if (sclk_run) sys_clk = ~sys_clk;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Disable, set the select, then enable on a falling edge.
    task automatic restart(input int sel);
        @(negedge wd_clk) en = 1'b0;
        repeat (3) @(negedge wd_clk);
        psel = 3'(sel);
        @(negedge wd_clk) en = 1'b1;
    endtask

    task automatic wait_evt(input int limit, output int cyc, output bit s_rst, output bit s_wake);
        cyc = 0; s_rst = 1'b0; s_wake = 1'b0;
        while (cyc < limit) begin
            @(posedge wd_clk);
            cyc++;
            @(negedge wd_clk);
            if (wd_reset) s_rst = 1'b1;
            if (wake) s_wake = 1'b1;
            if (s_rst || s_wake) break;
        end
    endtask

    task automatic t_reset_state();
        sys_rst_n = 1'b0; wd_rst_n = 1'b0;
        repeat (5) @(negedge wd_clk);
        sys_rst_n = 1'b1; wd_rst_n = 1'b1;
        chk(wd_reset == 1'b0, "R1 reset low", int'(wd_reset), 0);
        chk(wake == 1'b0, "R1 wake low", int'(wake), 0);
    endtask

    task automatic t_run_timeout(input int sel);
        int c; bit r; bit w;
        int per = 256 << sel;
        restart(sel);
        wait_evt(per + 50, c, r, w);
        chk(r && !w, "R2 reset on run time-out", int'(r), 1);
        chk(c == per, "R2 time-out period", c, per);
        @(posedge wd_clk);
        @(negedge wd_clk);
        chk(wd_reset == 1'b0, "R3 pulse width one cycle", int'(wd_reset), 0);
        wait_evt(per + 50, c, r, w);
        chk(r && c == per - 1, "R3 free-running next pulse", c, per - 1);
    endtask

    task automatic t_kick();
        int c; bit r; bit w;
        restart(0);
        wait_evt(150, c, r, w);
        chk(!r && !w, "R4 no time-out before kick", int'(r), 0);
        @(negedge sys_clk) kick = 1'b1;
        @(negedge sys_clk) kick = 1'b0;
        wait_evt(400, c, r, w);
        chk(r && c >= 257 && c <= 261, "R4 kick restarts count", c, 258);
    endtask

    task automatic t_disabled();
        int c; bit r; bit w;
        @(negedge wd_clk) en = 1'b0;
        wait_evt(700, c, r, w);
        chk(!r && !w && c == 700, "R8 disabled stays quiet", c, 700);
        restart(0);
        wait_evt(300, c, r, w);
        chk(r && c == 256, "R8 re-enable counts from zero", c, 256);
    endtask

    task automatic t_sleep_wake();
        int c; bit r; bit w; int lat;
        bit bad = 1'b0;
        @(negedge sys_clk) sleep = 1'b1;
        @(negedge sys_clk) sclk_run = 1'b0;   // system clock stopped low
        restart(0);
        wait_evt(400, c, r, w);
        chk(w && !r, "R5 wake instead of reset", int'(r), 0);
        chk(c == 256, "R7 counts with system clock stopped", c, 256);
        for (int i = 0; i < 20; i++) begin
            @(negedge wd_clk);
            if (!wake || wd_reset) bad = 1'b1;
        end
        chk(!bad, "R6 wake held without acknowledge", int'(bad), 0);
        sclk_run = 1'b1;
        ack = 1'b1;
        lat = 0;
        while (wake && lat < 10) begin
            @(negedge wd_clk);
            lat++;
        end
        chk(!wake && lat >= 1 && lat <= 4, "R6 wake drops after acknowledge", lat, 3);
        en = 1'b0;
        ack = 1'b0;
        sleep = 1'b0;
        repeat (5) @(negedge wd_clk);
        chk(wake == 1'b0 && wd_reset == 1'b0, "R6 wake stays low after release", int'(wake), 0);
    endtask

    initial begin
        t_reset_state();
        t_run_timeout(0);
        t_run_timeout(2);
        t_kick();
        t_disabled();
        t_sleep_wake();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule